// File: doc/BRIEF.md
# Accumulator Round, Window and Clamp Output Stage

This block turns a wide accumulator result into a narrow output sample. In every cycle it adds a signed offset taken from one of sixteen programmable round registers. It then cuts a 16-bit window out of the 32-bit sum, with the window position set by a shift value. Optionally it clamps that window between a lower and an upper bound. The bounds come from one of sixteen programmable limit registers. The round register, the window position and the limit register can all be chosen again in every cycle. This lets one stage serve several interleaved filter channels with different scaling.

The shaped sample is captured in an output register that has an active-low load enable, so a sample can be held for as long as needed. The pin driver has an active-low output enable that acts without a clock and floats the output. The round and limit registers are written through a single-cycle write port. A limit register packs its lower bound in bits 15:0 and its upper bound in bits 31:16.

Top module: `acc_window_limiter`

## Requirements
- R1: The round register chosen by `rnd_sel` is added to `acc_in`. The addition wraps modulo 2^32.
- R2: When the chosen round register holds zero, the 32-bit word that reaches the window stage equals `acc_in` unchanged.
- R3: A `shift` value s in 0..16 passes bits s+15 down to s of the rounded word.
- R4: A `shift` value above 16 gives the same window as 16, which is bits 31:16.
- R5: With `lim_en_n` low, the limit register chosen by `lim_sel` gives the lower bound (bits 15:0) and the upper bound (bits 31:16). A window that is below the lower bound in signed 16-bit comparison is replaced by the lower bound.
- R6: With `lim_en_n` low, a window that is above the upper bound in signed comparison is replaced by the upper bound. A window that lies between the bounds passes unchanged.
- R7: With `lim_en_n` high, the window passes without clamping.
- R8: The output register captures the shaped sample on a rising `clk` edge only while `oce_n` is low. While `oce_n` is high, it keeps its value.
- R9: While `oe_n` is high, all 16 bits of `dout` are high impedance, with no clock edge needed. While `oe_n` is low, `dout` shows the output register.
- R10: A write with `wr_en` high stores `wr_data` at index `wr_idx`. It goes to a round register when `wr_kind` is 0 and to a limit register when `wr_kind` is 1. The new value is used for samples presented from the cycle after the write edge.
- R11: After reset, the output register is 0 and every round register is 0. Every limit register holds lower bound 0x8000 and upper bound 0x7FFF, which is the full signed range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_in | input | 32 | Accumulator result, two's complement |
| rnd_sel | input | 4 | Round register select |
| shift | input | 5 | Window position (bit offset of the window LSB) |
| lim_sel | input | 4 | Limit register select |
| lim_en_n | input | 1 | Clamp enable, active low |
| oce_n | input | 1 | Output register load enable, active low |
| oe_n | input | 1 | Output drive enable, active low, acts without a clock |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 1 | Write target: 0 round register, 1 limit register |
| wr_idx | input | 4 | Register index for a write |
| wr_data | input | 32 | Write data |
| dout | output | 16 | Shaped sample, high impedance when disabled |

## Verification
The shaping path is combinational up to the output register. A sample presented before a rising edge therefore shows on `dout` after that one edge. The bench drives inputs on the falling edge and compares `dout` on the next falling edge. A register write needs one edge of its own, so the bench writes, waits one edge, and only then presents a sample that uses the new value. The float on `oe_n` has no clock in its path, and the bench checks it a nanosecond after toggling `oe_n`, between edges.

// File: rtl/wl_pkg.sv
package wl_pkg;
  localparam int unsigned WL_ACC_W = 32;
  localparam int unsigned WL_OUT_W = 16;
  localparam int unsigned WL_NREG  = 16;

  typedef enum logic {
    WL_TGT_ROUND = 1'b0,
    WL_TGT_LIMIT = 1'b1
  } wl_target_e;
endpackage

// File: rtl/wl_regbank.sv
module wl_regbank #(
  parameter int unsigned          N       = 16,
  parameter int unsigned          W       = 32,
  parameter logic [W-1:0]         RST_VAL = '0,
  localparam int unsigned         IDX_W   = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data
);
  logic [W-1:0] mem [N];

  for (genvar g = 0; g < N; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[g] <= RST_VAL;
      else if (hit) mem[g] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];

  // R10: a written entry reads back the written value on the next cycle
  p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/wl_shape.sv
module wl_shape #(
  parameter int unsigned  ACC_W  = 32,
  parameter int unsigned  OUT_W  = 16,
  localparam int unsigned MAX_SH = ACC_W - OUT_W,
  localparam int unsigned SH_W   = $clog2(MAX_SH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] acc,
  input  logic [ACC_W-1:0] rnd_val,
  input  logic [SH_W-1:0]  shift,
  input  logic [2*OUT_W-1:0] lim_val,
  input  logic             lim_en_n,
  output logic [ACC_W-1:0] rounded,
  output logic [OUT_W-1:0] window,
  output logic [OUT_W-1:0] shaped
);
  localparam logic [SH_W-1:0] MAX_SH_V = SH_W'(MAX_SH);

  function automatic logic [ACC_W-1:0] f_round(logic [ACC_W-1:0] a, logic [ACC_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [SH_W-1:0] f_sat_shift(logic [SH_W-1:0] s);
    return (s > MAX_SH_V) ? MAX_SH_V : s;
  endfunction

  function automatic logic [OUT_W-1:0] f_clamp(logic [OUT_W-1:0] v, logic [OUT_W-1:0] lo,
                                               logic [OUT_W-1:0] hi, logic bypass);
    if (bypass)                       return v;
    if ($signed(v) < $signed(lo))     return lo;
    if ($signed(v) > $signed(hi))     return hi;
    return v;
  endfunction

  logic [OUT_W-1:0] cand [MAX_SH+1];
  logic [SH_W-1:0]  sh_eff;
  logic [OUT_W-1:0] lo_b, hi_b;

  assign rounded = f_round(acc, rnd_val);
  assign sh_eff  = f_sat_shift(shift);

  for (genvar k = 0; k <= MAX_SH; k++) begin : g_win
    assign cand[k] = rounded[k +: OUT_W];
  end

  assign window = cand[sh_eff];
  assign lo_b   = lim_val[OUT_W-1:0];
  assign hi_b   = lim_val[2*OUT_W-1:OUT_W];
  assign shaped = f_clamp(window, lo_b, hi_b, lim_en_n);

  // R4: out-of-range shift saturates to the topmost window
  p_shift_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift > MAX_SH_V) |-> window == rounded[ACC_W-1 -: OUT_W]);
  // R5: clamped result never below an ordered lower bound
  p_lo_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lim_en_n && ($signed(lo_b) <= $signed(hi_b))) |-> ($signed(shaped) >= $signed(lo_b)));
  // R6: clamped result never above an ordered upper bound
  p_hi_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lim_en_n && ($signed(lo_b) <= $signed(hi_b))) |-> ($signed(shaped) <= $signed(hi_b)));
  // R7: bypass leaves the window untouched
  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lim_en_n |-> shaped == window);
endmodule

// File: rtl/acc_window_limiter.sv
module acc_window_limiter
  import wl_pkg::*;
#(
  parameter int unsigned  ACC_W  = WL_ACC_W,
  parameter int unsigned  OUT_W  = WL_OUT_W,
  parameter int unsigned  NREG   = WL_NREG,
  localparam int unsigned SEL_W  = $clog2(NREG),
  localparam int unsigned SH_W   = $clog2(ACC_W - OUT_W + 1),
  localparam int unsigned LIM_W  = 2 * OUT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] acc_in,
  input  logic [SEL_W-1:0] rnd_sel,
  input  logic [SH_W-1:0]  shift,
  input  logic [SEL_W-1:0] lim_sel,
  input  logic             lim_en_n,
  input  logic             oce_n,
  input  logic             oe_n,
  input  logic             wr_en,
  input  logic             wr_kind,
  input  logic [SEL_W-1:0] wr_idx,
  input  logic [ACC_W-1:0] wr_data,
  output logic [OUT_W-1:0] dout
);
  localparam logic [LIM_W-1:0] LIM_RST = {1'b0, {(OUT_W-1){1'b1}}, 1'b1, {(OUT_W-1){1'b0}}};

  logic             wr_round, wr_limit;
  logic [ACC_W-1:0] rnd_val;
  logic [ACC_W-1:0] lim_raw;
  logic [LIM_W-1:0] lim_val;
  logic [ACC_W-1:0] rounded;
  logic [OUT_W-1:0] window;
  logic [OUT_W-1:0] shaped;
  logic [OUT_W-1:0] out_q;

  assign wr_round = wr_en && (wl_target_e'(wr_kind) == WL_TGT_ROUND);
  assign wr_limit = wr_en && (wl_target_e'(wr_kind) == WL_TGT_LIMIT);

  wl_regbank #(.N(NREG), .W(ACC_W), .RST_VAL('0)) u_round (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_round), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rnd_sel), .rd_data(rnd_val));

  wl_regbank #(.N(NREG), .W(ACC_W), .RST_VAL(ACC_W'(LIM_RST))) u_limit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_limit), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(lim_sel), .rd_data(lim_raw));

  assign lim_val = lim_raw[LIM_W-1:0];

  wl_shape #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_shape (
    .clk(clk), .rst_n(rst_n), .acc(acc_in), .rnd_val(rnd_val), .shift(shift),
    .lim_val(lim_val), .lim_en_n(lim_en_n), .rounded(rounded),
    .window(window), .shaped(shaped));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (!oce_n) out_q <= shaped;
  end

  assign dout = oe_n ? {OUT_W{1'bz}} : out_q;

  // R8: a disabled output register keeps its contents
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oce_n |=> out_q == $past(out_q));
  // R8: an enabled output register takes the shaped sample of the prior cycle
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !oce_n |=> out_q == $past(shaped));
  // R2: zero offset leaves the accumulator word as it is
  p_zero_round_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_val == '0) |-> rounded == acc_in);
endmodule

// File: tb/sim_acc_window_limiter.sv
`timescale 1ns/1ps
module sim_acc_window_limiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] acc_in = '0;
  logic [3:0]  rnd_sel = '0;
  logic [4:0]  shift = '0;
  logic [3:0]  lim_sel = '0;
  logic        lim_en_n = 1'b1;
  logic        oce_n = 1'b1;
  logic        oe_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_kind = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  wire  [15:0] dout;

  int total = 0;
  int bad = 0;
  logic [31:0] rnd_m [16];
  logic [31:0] lim_m [16];

  always #10 clk = ~clk;

  acc_window_limiter u0 (
    .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .rnd_sel(rnd_sel), .shift(shift),
    .lim_sel(lim_sel), .lim_en_n(lim_en_n), .oce_n(oce_n), .oe_n(oe_n),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data), .dout(dout));

  function automatic logic [15:0] model(logic [31:0] a, logic [3:0] rs, logic [4:0] sh,
                                        logic [3:0] ls, logic len_n);
    logic [31:0] sum;
    int          pos;
    logic [15:0] w, lo, hi;
    sum = a + rnd_m[rs];
    pos = (sh > 5'd16) ? 16 : int'(sh);
    for (int i = 0; i < 16; i++) w[i] = sum[pos + i];
    lo = lim_m[ls][15:0];
    hi = lim_m[ls][31:16];
    if (!len_n) begin
      if ($signed(w) < $signed(lo)) w = lo;
      else if ($signed(w) > $signed(hi)) w = hi;
    end
    return w;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic kind, logic [3:0] idx, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = kind; wr_idx = idx; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    if (kind) lim_m[idx] = d; else rnd_m[idx] = d;
  endtask

  task automatic run(string req, logic [31:0] a, logic [3:0] rs, logic [4:0] sh,
                     logic [3:0] ls, logic len_n);
    @(negedge clk);
    acc_in = a; rnd_sel = rs; shift = sh; lim_sel = ls; lim_en_n = len_n; oce_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(req, dout, model(a, rs, sh, ls, len_n));
  endtask

  task automatic t_reset;  // R11
    chk("R11 out reg", dout, 16'h0000);
    run("R11 round regs zero", 32'h1357_9BDF, 4'd9, 5'd4, 4'd0, 1'b1);
    run("R11 full-range limit", 32'h0000_8000, 4'd0, 5'd0, 4'd12, 1'b0);
    chk("R11 limit lower 8000", dout, 16'h8000);
  endtask

  task automatic t_round;  // R1 R10
    wr(1'b0, 4'd3, 32'h0000_0080);
    run("R1 add offset", 32'h0000_1234, 4'd3, 5'd8, 4'd0, 1'b1);
    chk("R1 add offset value", dout, 16'h0012);
    wr(1'b0, 4'd15, 32'hFFFF_FFFF);
    run("R1 wrap", 32'h0000_0001, 4'd15, 5'd0, 4'd0, 1'b1);
    chk("R1 wrap value", dout, 16'h0000);
    wr(1'b1, 4'd3, 32'h0010_0000);
    run("R10 limit write leaves round reg", 32'h0000_1234, 4'd3, 5'd8, 4'd0, 1'b1);
    chk("R10 round reg intact", dout, 16'h0012);
  endtask

  task automatic t_zero_round;  // R2
    run("R2 zero offset low", 32'hABCD_1234, 4'd0, 5'd0, 4'd0, 1'b1);
    chk("R2 low half", dout, 16'h1234);
    run("R2 zero offset high", 32'hABCD_1234, 4'd0, 5'd16, 4'd0, 1'b1);
    chk("R2 high half", dout, 16'hABCD);
  endtask

  task automatic t_shift;  // R3 R4
    for (int s = 0; s <= 16; s++) run("R3 window", 32'h89AB_CDEF, 4'd0, 5'(s), 4'd0, 1'b1);
    run("R4 shift 17", 32'h89AB_CDEF, 4'd0, 5'd17, 4'd0, 1'b1);
    chk("R4 shift 17 top", dout, 16'h89AB);
    run("R4 shift 31", 32'h89AB_CDEF, 4'd0, 5'd31, 4'd0, 1'b1);
    chk("R4 shift 31 top", dout, 16'h89AB);
  endtask

  task automatic t_limit;  // R5 R6 R7 R10
    wr(1'b1, 4'd5, 32'h0100_FF00);
    run("R5 below lower", 32'hFFFF_FC18, 4'd0, 5'd0, 4'd5, 1'b0);
    chk("R5 lower bound", dout, 16'hFF00);
    run("R6 above upper", 32'h0000_7000, 4'd0, 5'd0, 4'd5, 1'b0);
    chk("R6 upper bound", dout, 16'h0100);
    run("R6 inside", 32'h0000_0050, 4'd0, 5'd0, 4'd5, 1'b0);
    chk("R6 inside passes", dout, 16'h0050);
    run("R7 bypass", 32'h0000_7000, 4'd0, 5'd0, 4'd5, 1'b1);
    chk("R7 bypass value", dout, 16'h7000);
    run("R5 other reg", 32'h0000_7000, 4'd0, 5'd0, 4'd6, 1'b0);
    chk("R5 per-cycle select", dout, 16'h7000);
  endtask

  task automatic t_hold;  // R8
    run("R8 load", 32'h0000_1111, 4'd0, 5'd0, 4'd0, 1'b1);
    @(negedge clk);
    oce_n = 1'b1; acc_in = 32'h0000_2222;
    @(posedge clk); @(negedge clk);
    chk("R8 hold 1", dout, 16'h1111);
    @(posedge clk); @(negedge clk);
    chk("R8 hold 2", dout, 16'h1111);
    oce_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R8 reload", dout, 16'h2222);
  endtask

  task automatic t_oe;  // R9
    @(negedge clk);
    #1 oe_n = 1'b1;
    #1 chk("R9 float", dout, 16'hzzzz);
    #1 oe_n = 1'b0;
    #1 chk("R9 drive", dout, 16'h2222);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      rnd_m[i] = '0;
      lim_m[i] = 32'h7FFF_8000;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_round();
    t_zero_round();
    t_shift();
    t_limit();
    t_hold();
    t_oe();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule